// File: doc/BRIEF.md
# I2C EEPROM Page-Write Controller

This block is the write-side slave front end of a 256-location, byte-wide nonvolatile-style store. The store is modelled as a register array. The block watches an I2C bus, with SCL and SDA brought into the system clock domain through synchronizers. It accepts a write transaction made of three parts: a device address byte, one word-address byte, and a burst of up to eight data bytes. The data bytes are held in a page buffer until the master ends the transfer with a STOP.

On a clean STOP the buffered bytes are committed to the array in one step. The controller then enters a busy period whose length is the number of committed bytes times a per-byte interval given as a parameter. During that period the block answers nothing on the bus. A transfer can also end with an over-long burst, a STOP in the middle of a byte, or a repeated START. In each of those cases the buffer is dropped and no busy period follows.

A registered debug port lets a test environment read any array location without going through the bus.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset SDA is released (sdaOe = 0) and every array location reads 0 through the debug port.
- R2: The device address byte is acknowledged only when its upper seven bits equal binary 1010 followed by strap[2:0] and its last bit (read/write flag) is 0. Otherwise no byte is acknowledged until the next START.
- R3: The byte after an accepted device address is acknowledged and taken as the 8-bit word address.
- R4: Data bytes are acknowledged and buffered at successive addresses. Only the low three address bits advance, wrapping modulo 8, and the high five bits stay fixed for the transaction.
- R5: A STOP after one to eight data bytes writes exactly those bytes to the array. No other location changes.
- R6: A ninth data byte, and every byte after it, is not acknowledged, and the whole transaction writes nothing.
- R7: A STOP that arrives with two or more bits of a byte already clocked, or a repeated START, discards the buffered data without writing.
- R8: A STOP directly after the word address writes nothing and starts no busy period. The next transaction is served at once.
- R9: After a committing STOP the block acknowledges no address for n × BYTE_CYCLES clocks, where n is the number of bytes committed. After that window it answers again.
- R10: SDA is pulled low only during the ninth clock of an accepted byte. It is released on the SCL falling edge that ends that clock.
- R11: dbgData shows the array contents at dbgAddr one clock after dbgAddr is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen on the pin |
| sdaIn | input | 1 | Bus data line as seen on the pin |
| strap | input | 3 | Low three bits of the device address |
| sdaOe | output | 1 | When 1, the pad pulls SDA low (open drain) |
| dbgAddr | input | 8 | Debug read address |
| dbgData | output | 8 | Debug read data, registered |

## Verification
Single-byte writes separate the basic commit path from the page logic. A full eight-byte burst that starts in the middle of a page shows whether the low address bits wrap while the high bits stay put. Nine- and ten-byte bursts, wrong prefixes, wrong straps and a set read flag each expect every following acknowledge to be missing and the array to stay unchanged. A STOP in mid-byte, a repeated START and a STOP right after the word address are told apart by whether a later address probe is answered at once and by which locations change. Repeated address probes after 1-byte and 3-byte commits measure when the busy window ends, which shows that it scales with the byte count. Seeded random bursts of one to nine bytes are then compared with a bench model of the array.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_IGNORE,
    ST_BUSY
  } pwState_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_WADDR,
    PH_DATA
  } pwPhase_t;

  typedef struct packed {
    logic shiftEn;
    logic loadAddr;
    logic storeByte;
    logic clearBuf;
    logic commit;
  } pwStrobes_t;

endpackage

// File: rtl/pwLineSync.sv
module pwLineSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sclPipe[0] <= 1'b1;
            sdaPipe[0] <= 1'b1;
          end else begin
            sclPipe[0] <= sclIn;
            sdaPipe[0] <= sdaIn;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sclPipe[s] <= 1'b1;
            sdaPipe[s] <= 1'b1;
          end else begin
            sclPipe[s] <= sclPipe[s-1];
            sdaPipe[s] <= sdaPipe[s-1];
          end
        end
      end
    end
  endgenerate

  assign sclNow = sclPipe[STAGES-1];
  assign sdaNow = sdaPipe[STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sdaS     = sdaNow;
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;

endmodule

// File: rtl/pwControl.sv
module pwControl
  import eeprom_pw_pkg::*;
#(
  parameter int          PAGE_BYTES  = 8,
  parameter int          BYTE_CYCLES = 700000,
  parameter logic [3:0]  DEV_PREFIX  = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [7:0] rxByte,
  input  logic [2:0] strap,
  output pwStrobes_t strobes,
  output logic       sdaOe
);

  localparam int CNT_W  = $clog2(PAGE_BYTES + 1);
  localparam int BUSY_W = $clog2(BYTE_CYCLES * PAGE_BYTES + 1);

  pwState_t          state, stateN;
  pwPhase_t          phase, phaseN;
  logic [3:0]        bitCnt, bitCntN;
  logic [CNT_W-1:0]  byteCnt, byteCntN;
  logic [BUSY_W-1:0] busyCnt, busyCntN;
  logic              canCommit;

  assign canCommit = (state == ST_RX) && (phase == PH_DATA) &&
                     (bitCnt <= 4'd1) && (byteCnt != '0);

  always_comb begin
    stateN   = state;
    phaseN   = phase;
    bitCntN  = bitCnt;
    byteCntN = byteCnt;
    busyCntN = busyCnt;
    strobes  = '0;
    if (state == ST_BUSY) begin
      busyCntN = busyCnt - BUSY_W'(1);
      if (busyCnt == BUSY_W'(1)) stateN = ST_IDLE;
    end else if (startDet) begin
      stateN   = ST_RX;
      phaseN   = PH_DEV;
      bitCntN  = '0;
      byteCntN = '0;
      strobes.clearBuf = 1'b1;
    end else if (stopDet) begin
      if (canCommit) begin
        strobes.commit = 1'b1;
        stateN   = ST_BUSY;
        busyCntN = BUSY_W'(32'(byteCnt) * BYTE_CYCLES);
      end else begin
        stateN = ST_IDLE;
        strobes.clearBuf = 1'b1;
      end
      byteCntN = '0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise && bitCnt != 4'd8) begin
            strobes.shiftEn = 1'b1;
            bitCntN = bitCnt + 4'd1;
          end
          if (sclFall && bitCnt == 4'd8) begin
            case (phase)
              PH_DEV: begin
                if (rxByte == {DEV_PREFIX, strap, 1'b0}) begin
                  stateN = ST_ACK;
                  phaseN = PH_WADDR;
                end else begin
                  stateN = ST_IGNORE;
                end
              end
              PH_WADDR: begin
                strobes.loadAddr = 1'b1;
                stateN = ST_ACK;
                phaseN = PH_DATA;
              end
              default: begin
                if (byteCnt < CNT_W'(PAGE_BYTES)) begin
                  strobes.storeByte = 1'b1;
                  byteCntN = byteCnt + 1'b1;
                  stateN   = ST_ACK;
                end else begin
                  strobes.clearBuf = 1'b1;
                  byteCntN = '0;
                  stateN   = ST_IGNORE;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            stateN  = ST_RX;
            bitCntN = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= PH_DEV;
      bitCnt  <= '0;
      byteCnt <= '0;
      busyCnt <= '0;
    end else begin
      state   <= stateN;
      phase   <= phaseN;
      bitCnt  <= bitCntN;
      byteCnt <= byteCntN;
      busyCnt <= busyCntN;
    end
  end

  assign sdaOe = (state == ST_ACK);

  // Busy is entered only through a detected STOP
  assert_busy_after_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_BUSY) |-> $past(stopDet));

  // No acknowledge can be driven while the write cycle runs
  assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |=> (!sdaOe || $past(busyCnt) == BUSY_W'(1)) && state != ST_ACK);

  // Release SDA on the falling edge that ends the acknowledge clock
  assert_ack_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK && sclFall && !startDet && !stopDet) |=> !sdaOe);

  // Ninth data byte receives no acknowledge
  assert_ninth_nack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RX && phase == PH_DATA && bitCnt == 4'd8 && sclFall &&
     byteCnt == CNT_W'(PAGE_BYTES) && !startDet && !stopDet) |=> !sdaOe);

endmodule

// File: rtl/pwDatapath.sv
module pwDatapath
  import eeprom_pw_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaS,
  input  pwStrobes_t        strobes,
  output logic [7:0]        rxByte,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic [7:0]        dbgData
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [7:0]            shiftReg;
  logic [ADDR_W-1:0]     wordAddr;
  logic [7:0]            pageBuf   [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] slotValid;
  logic [7:0]            memArr    [DEPTH];

  assign rxByte = shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      wordAddr <= '0;
    end else begin
      if (strobes.shiftEn) shiftReg <= {shiftReg[6:0], sdaS};
      if (strobes.loadAddr) wordAddr <= shiftReg[ADDR_W-1:0];
      else if (strobes.storeByte)
        wordAddr[PAGE_W-1:0] <= wordAddr[PAGE_W-1:0] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= '0;
      for (int j = 0; j < PAGE_BYTES; j++) pageBuf[j] <= '0;
    end else if (strobes.clearBuf || strobes.commit) begin
      slotValid <= '0;
    end else if (strobes.storeByte) begin
      pageBuf[wordAddr[PAGE_W-1:0]]   <= shiftReg;
      slotValid[wordAddr[PAGE_W-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) memArr[a] <= '0;
    end else if (strobes.commit) begin
      for (int j = 0; j < PAGE_BYTES; j++)
        if (slotValid[j])
          memArr[{wordAddr[ADDR_W-1:PAGE_W], PAGE_W'(j)}] <= pageBuf[j];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dbgData <= '0;
    else       dbgData <= memArr[dbgAddr];
  end

  // Low bits step by one inside the page, high bits hold
  assert_page_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeByte |=>
      (wordAddr[ADDR_W-1:PAGE_W] == $past(wordAddr[ADDR_W-1:PAGE_W])) &&
      (wordAddr[PAGE_W-1:0] == $past(wordAddr[PAGE_W-1:0]) + PAGE_W'(1)));

  // A commit or discard leaves the page buffer empty
  assert_buf_drained_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit || strobes.clearBuf) |=> (slotValid == '0));

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eeprom_pw_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_BYTES  = 8,
  parameter int         BYTE_CYCLES = 700000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_PREFIX  = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        strap,
  output logic              sdaOe,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic [7:0]        dbgData
);

  logic       sdaS, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rxByte;
  pwStrobes_t strobes;

  pwLineSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  pwControl #(
    .PAGE_BYTES(PAGE_BYTES), .BYTE_CYCLES(BYTE_CYCLES), .DEV_PREFIX(DEV_PREFIX)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .rxByte(rxByte),
    .strap(strap), .strobes(strobes), .sdaOe(sdaOe)
  );

  pwDatapath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) uData (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .strobes(strobes),
    .rxByte(rxByte), .dbgAddr(dbgAddr), .dbgData(dbgData)
  );

endmodule

// File: tb/eeprom_page_writer_test.sv
module eeprom_page_writer_test;

  localparam int CLK_PERIOD = 10;
  localparam int BC         = 200;
  localparam int HALF       = 10;
  localparam int LIMIT      = 190000;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV   = {4'b1010, STRAP, 1'b0};

  logic clk = 1'b0, rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaOe;
  logic sdaIn;
  logic [7:0] dbgAddr = '0, dbgData;

  int nChecks = 0, nFail = 0, cyc = 0;
  int tStartMark = 0, tStopMark = 0;
  bit finished = 0;
  logic [7:0] modelMem [256];
  logic [7:0] txData [16];
  bit ackLog [18];

  assign sdaIn = sdaDrv & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_page_writer #(.BYTE_CYCLES(BC)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaIn), .strap(STRAP),
    .sdaOe(sdaOe), .dbgAddr(dbgAddr), .dbgData(dbgData)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > LIMIT && !finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: act %0d cycles exp <= %0d", cyc, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    idle(2); sdaDrv = 1'b1; idle(HALF);
    sclDrv = 1'b1; idle(HALF);
    sdaDrv = 1'b0; tStartMark = cyc; idle(HALF);
    sclDrv = 1'b0;
  endtask

  task automatic busStop();
    idle(2); sdaDrv = 1'b0; idle(HALF);
    sclDrv = 1'b1; idle(HALF);
    sdaDrv = 1'b1; tStopMark = cyc; idle(HALF);
  endtask

  task automatic sendBit(input logic v);
    idle(2); sdaDrv = v; idle(HALF - 2);
    sclDrv = 1'b1; idle(HALF);
    sclDrv = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    idle(2); sdaDrv = 1'b1; idle(HALF - 2);
    sclDrv = 1'b1; idle(HALF/2);
    ack = sdaOe;
    idle(HALF/2);
    sclDrv = 1'b0;
    idle(6);
    if (ack) check(sdaOe == 1'b0, "R10 release after ninth clock", sdaOe, 0);
  endtask

  task automatic doWrite(input logic [7:0] dev, input logic [7:0] waddr,
                         input int n, input bit withStop);
    busStart();
    sendByte(dev, ackLog[0]);
    sendByte(waddr, ackLog[1]);
    for (int i = 0; i < n; i++) sendByte(txData[i], ackLog[2+i]);
    if (withStop) busStop();
  endtask

  task automatic probe(output bit ack);
    busStart();
    sendByte(DEV, ack);
    busStop();
  endtask

  task automatic checkAcks(input bit devOk, input int n, input string req);
    int bad = 0, firstI = -1;
    for (int i = 0; i < n + 2; i++) begin
      bit expA = devOk && (i < 2 || i - 2 < 8);
      if (ackLog[i] != expA) begin bad++; if (firstI < 0) firstI = i; end
    end
    check(bad == 0, req, firstI, -1);
  endtask

  function automatic void modelWrite(input logic [7:0] waddr, input int n);
    for (int i = 0; i < n; i++)
      modelMem[{waddr[7:3], 3'(waddr[2:0] + 3'(i))}] = txData[i];
  endfunction

  task automatic readMem(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); dbgAddr = a;
    @(negedge clk); d = dbgData;
  endtask

  task automatic sweep(input string req);
    int bad = 0, firstA = -1, act = 0, exp = 0;
    logic [7:0] d;
    for (int a = 0; a < 256; a++) begin
      readMem(8'(a), d);
      if (d !== modelMem[a]) begin
        bad++;
        if (firstA < 0) begin firstA = a; act = int'(d); exp = int'(modelMem[a]); end
      end
    end
    check(bad == 0, req, act, exp);
    if (bad != 0) $display("  first mismatch at 0x%0h, %0d total", firstA, bad);
  endtask

  task automatic fillRandom(input int n);
    for (int i = 0; i < n; i++) txData[i] = 8'($urandom);
  endtask

  task automatic busyWindow(input int n, input logic [7:0] waddr, input string req);
    bit ack;
    int t0, d, tries;
    fillRandom(n);
    doWrite(DEV, waddr, n, 1);
    t0 = tStopMark;
    modelWrite(waddr, n);
    probe(ack);
    check(ack == 1'b0, {req, " first probe during busy"}, ack, 0);
    tries = 0;
    while (!ack && tries < 40) begin probe(ack); tries++; end
    d = tStartMark - t0;
    check(ack && d >= n * BC - 4 && d <= n * BC + 300, {req, " busy length"}, d, n * BC);
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    for (int a = 0; a < 256; a++) modelMem[a] = '0;
    idle(5);
    rstN = 1'b1;
    idle(5);

    // R1: reset state
    check(sdaOe == 1'b0, "R1 sda released after reset", sdaOe, 0);
    sweep("R1 array cleared / R11 debug read");

    // R2 R3 R5: single byte
    txData[0] = 8'h5A;
    doWrite(DEV, 8'h10, 1, 1);
    checkAcks(1, 1, "R2 R3 R5 single byte acks");
    modelWrite(8'h10, 1);
    idle(BC + 20);
    readMem(8'h10, d);
    check(d == 8'h5A, "R11 debug read of written byte", d, 8'h5A);
    sweep("R5 single byte commit");

    // R4: full page from mid-page, wraps
    for (int i = 0; i < 8; i++) txData[i] = 8'(8'hA0 + i);
    doWrite(DEV, 8'h25, 8, 1);
    checkAcks(1, 8, "R4 eight byte acks");
    modelWrite(8'h25, 8);
    idle(8 * BC + 20);
    readMem(8'h20, d);
    check(d == 8'hA3, "R4 wrap to page base", d, 8'hA3);
    readMem(8'h28, d);
    check(d == 8'h00, "R4 next page untouched", d, 0);
    sweep("R4 page wrap contents");

    // R6: nine and ten byte bursts
    fillRandom(10);
    doWrite(DEV, 8'h40, 10, 1);
    checkAcks(1, 10, "R6 ninth and later bytes not acked");
    probe(ack);
    check(ack == 1'b1, "R6 no busy after aborted burst", ack, 1);
    sweep("R6 nothing written");

    // R2: bad prefix, bad strap, read flag
    txData[0] = 8'h11;
    doWrite({4'b1011, STRAP, 1'b0}, 8'h50, 1, 1);
    checkAcks(0, 1, "R2 wrong prefix");
    doWrite({4'b1010, 3'b001, 1'b0}, 8'h50, 1, 1);
    checkAcks(0, 1, "R2 wrong strap");
    doWrite({4'b1010, STRAP, 1'b1}, 8'h50, 1, 1);
    checkAcks(0, 1, "R2 read flag set");
    sweep("R2 no write from unmatched address");

    // R8: stop right after word address
    doWrite(DEV, 8'h70, 0, 1);
    checkAcks(1, 0, "R8 address-only acks");
    probe(ack);
    check(ack == 1'b1, "R8 no busy after address-only", ack, 1);
    sweep("R8 nothing written");

    // R7: stop mid-byte
    txData[0] = 8'h77;
    doWrite(DEV, 8'h90, 1, 0);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    busStop();
    probe(ack);
    check(ack == 1'b1, "R7 no busy after mid-byte stop", ack, 1);
    sweep("R7 mid-byte stop discards");

    // R7: repeated start discards first burst
    txData[0] = 8'h31; txData[1] = 8'h32;
    doWrite(DEV, 8'h80, 2, 0);
    txData[0] = 8'h99;
    doWrite(DEV, 8'h98, 1, 1);
    checkAcks(1, 1, "R7 second transaction acks");
    modelWrite(8'h98, 1);
    idle(BC + 20);
    sweep("R7 repeated start keeps only second burst");

    // R9: busy window scales with byte count
    busyWindow(3, 8'h60, "R9 three bytes");
    busyWindow(1, 8'h67, "R9 one byte");
    sweep("R9 commits during busy tests");

    // Random bursts, some over-long
    for (int t = 0; t < 10; t++) begin
      int n = 1 + int'($urandom % 9);
      logic [7:0] wa = 8'($urandom);
      fillRandom(n);
      doWrite(DEV, wa, n, 1);
      checkAcks(1, n, "R4 R5 R6 random burst acks");
      if (n <= 8) begin
        modelWrite(wa, n);
        idle(n * BC + 20);
      end else idle(20);
    end
    sweep("R5 random bursts final contents");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule